// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform of an I2C master and two strobes that tell the data path when SDA may change and when it should be sampled. Every interval is counted from a fast input clock, using a set of programmed timing fields: a prescale divider, the SCL low and high counts, setup and hold counts for START, a setup count for STOP, data setup and data hold counts, a bus release count and a glitch-filter length. Only the standard/fast timing set is covered. There is no clock stretching.

A transfer begins with a start request while the block is idle. The generator then emits a START condition and runs data-bit clocks. At the end of each bit it samples a next-operation input, which selects another bit, a STOP or a repeated START. For the bus conditions the generator owns SDA through a three-way mode output (forced low, released high, or owned by the data path). During bit phases the data path drives SDA, timed by the change strobe and the sample strobe. The timing fields sit in 32-bit words at fixed bit positions, so the words can be wired straight from a register file. The fields must stay stable while the block is busy. A change takes effect one clock after it is applied.

Top module: `i2c_sclgen`

## Requirements
- R1: After reset, and whenever the block is idle (busy_o low), scl_o is 1, sda_mode_o is release (2'b10), and sda_chg_o and sda_smp_o are 0.
- R2: Let D = div+1, where div sits in tw_div_i[23:16]. Let F be the filter length in cfg_i[18:16]. The SCL low field is tw_bit_i[15:8] and the high field is tw_bit_i[7:0]. A data bit holds scl_o low for D*(low+1)+4+F clocks and then high for D*(high+1)+4+F clocks. One bit period is therefore D*(low+high+2)+8+2F clocks.
- R3: A start_i pulse while idle raises busy_o on the next clock. SCL then stays high with SDA released for D*(ssu+1) clocks, where ssu is tw_cond_i[31:24]. SDA is then forced low (mode 2'b01), with SCL still high, for D*(shd+1) clocks, where shd is tw_cond_i[23:16]. After that SCL falls into the first data bit.
- R4: start_i has no effect while busy_o is high. The interval lengths of the running transfer are unchanged.
- R5: In each data-bit low phase, sda_chg_o pulses once, and SDA is owned by the data path (mode 2'b00). Let H = D*(hold+1), where hold is tw_hold_i[7:0], and S = D*(dsu+1), where dsu is tw_bit_i[31:24]. Let L be the low length. The pulse comes H clocks after SCL falls when H+S <= L, L-S clocks after when S < L < H+S, and in the first low clock otherwise.
- R6: sda_smp_o pulses exactly once per data bit, in the first clock that SCL is high. It never pulses during START, STOP or release intervals.
- R7: next_op_i is sampled in the last high clock of a bit. The code 2'b01 selects STOP: SCL low with SDA forced low for the low length, then SCL high with SDA low for D*(psu+1) clocks (psu = tw_cond_i[15:8]), then SCL high with SDA released for D*(rel+1) clocks (rel = tw_div_i[7:0]), then idle.
- R8: The code 2'b10 selects a repeated START: SCL low with SDA released for the low length, followed by the START sequence of R3. The codes 2'b00 and 2'b11 run another data bit.
- R9: The SDA mode switches between forced low and released only while SCL is high in both the old and the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all intervals are counted in |
| rst | input | 1 | Synchronous active-high reset |
| tw_cond_i | input | 32 | START setup [31:24], START hold [23:16], STOP setup [15:8] |
| tw_bit_i | input | 32 | Data setup [31:24], SCL low [15:8], SCL high [7:0] |
| tw_div_i | input | 32 | Prescale divider [23:16], bus release count [7:0] |
| tw_hold_i | input | 32 | Data hold [7:0] |
| cfg_i | input | 32 | Filter length [18:16] |
| start_i | input | 1 | Begin a transfer when idle |
| next_op_i | input | 2 | Action after the current bit: 00/11 bit, 01 stop, 10 repeated start |
| scl_o | output | 1 | Registered SCL level |
| sda_mode_o | output | 2 | SDA owner: 00 data path, 01 forced low, 10 released |
| sda_chg_o | output | 1 | One-clock strobe: data may change now |
| sda_smp_o | output | 1 | One-clock strobe: sample SDA now |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench measures every interval as a run of constant (busy, SCL, SDA mode) samples. It does this for a zero-field configuration, where each low and high phase shrinks to the fixed overhead, and for a large divider with the maximum filter. An off-by-one in the prescale product, or a filter term that is dropped or not doubled, shows up as a wrong run length or a wrong bit period. The change strobe is checked in all three placements: hold-bound, setup-bound, and a setup count that exceeds the low phase. A design that ignores the setup rule would pulse too late, or never. The bench also holds start_i high through a repeated-start frame. A design that re-arms on that input would cut a phase short or restart the START sequence.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  localparam int FLD_W = 8;
  localparam int FLT_W = 3;
  localparam int WORD_W = 32;
  localparam int LEN_W = 2 * FLD_W + 2;
  localparam int OVH_HALF = 4;

  // field positions inside the timing words
  localparam int POS_SSU = 24;
  localparam int POS_SHD = 16;
  localparam int POS_PSU = 8;
  localparam int POS_DSU = 24;
  localparam int POS_LOW = 8;
  localparam int POS_HIGH = 0;
  localparam int POS_DIV = 16;
  localparam int POS_REL = 0;
  localparam int POS_DHD = 0;
  localparam int POS_FLT = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S_SU, ST_S_HD, ST_B_LOW, ST_B_HIGH,
    ST_P_LOW, ST_P_SU, ST_P_FREE, ST_R_LOW
  } phase_e;

  typedef enum logic [1:0] {
    SDA_DATA = 2'b00,
    SDA_LOW  = 2'b01,
    SDA_REL  = 2'b10
  } sda_mode_e;

  typedef struct packed {
    logic [LEN_W-1:0] low;
    logic [LEN_W-1:0] high;
    logic [LEN_W-1:0] ssu;
    logic [LEN_W-1:0] shd;
    logic [LEN_W-1:0] psu;
    logic [LEN_W-1:0] rel;
    logic [LEN_W-1:0] chg_at;
  } lens_t;

  function automatic logic scl_of(phase_e p);
    return !(p == ST_B_LOW || p == ST_P_LOW || p == ST_R_LOW);
  endfunction

  function automatic sda_mode_e mode_of(phase_e p);
    case (p)
      ST_S_HD, ST_P_LOW, ST_P_SU: return SDA_LOW;
      ST_B_LOW, ST_B_HIGH:        return SDA_DATA;
      default:                    return SDA_REL;
    endcase
  endfunction
endpackage

// File: rtl/i2c_sclgen_calc.sv
module i2c_sclgen_calc
  import i2c_sclgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tw_cond_i,
  input  logic [WORD_W-1:0] tw_bit_i,
  input  logic [WORD_W-1:0] tw_div_i,
  input  logic [WORD_W-1:0] tw_hold_i,
  input  logic [WORD_W-1:0] cfg_i,
  output lens_t             lens_o
);
  localparam int NF = 8;
  localparam int F_LOW = 0, F_HIGH = 1, F_SSU = 2, F_SHD = 3;
  localparam int F_PSU = 4, F_DSU = 5, F_DHD = 6, F_REL = 7;

  logic [FLD_W-1:0] fld [NF];
  logic [FLD_W-1:0] div;
  logic [LEN_W-1:0] prod [NF];
  logic [LEN_W-1:0] ovh, low_len, chg_at;

  assign fld[F_LOW]  = tw_bit_i[POS_LOW +: FLD_W];
  assign fld[F_HIGH] = tw_bit_i[POS_HIGH +: FLD_W];
  assign fld[F_SSU]  = tw_cond_i[POS_SSU +: FLD_W];
  assign fld[F_SHD]  = tw_cond_i[POS_SHD +: FLD_W];
  assign fld[F_PSU]  = tw_cond_i[POS_PSU +: FLD_W];
  assign fld[F_DSU]  = tw_bit_i[POS_DSU +: FLD_W];
  assign fld[F_DHD]  = tw_hold_i[POS_DHD +: FLD_W];
  assign fld[F_REL]  = tw_div_i[POS_REL +: FLD_W];
  assign div         = tw_div_i[POS_DIV +: FLD_W];

  logic unused_bits;
  assign unused_bits = ^{tw_cond_i[7:0], tw_bit_i[23:16], tw_div_i[31:24],
                         tw_div_i[15:8], tw_hold_i[31:8], cfg_i[31:19], cfg_i[15:0]};

  // every interval is a whole number of prescaled units
  for (genvar g = 0; g < NF; g++) begin : g_scale
    assign prod[g] = (LEN_W'(div) + LEN_W'(1)) * (LEN_W'(fld[g]) + LEN_W'(1));
  end

  assign ovh     = LEN_W'(OVH_HALF) + LEN_W'(cfg_i[POS_FLT +: FLT_W]);
  assign low_len = prod[F_LOW] + ovh;

  always_comb begin
    if (prod[F_DHD] + prod[F_DSU] <= low_len) chg_at = prod[F_DHD];
    else if (prod[F_DSU] < low_len)          chg_at = low_len - prod[F_DSU];
    else                                      chg_at = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lens_o <= '0;
    end else begin
      lens_o.low    <= low_len;
      lens_o.high   <= prod[F_HIGH] + ovh;
      lens_o.ssu    <= prod[F_SSU];
      lens_o.shd    <= prod[F_SHD];
      lens_o.psu    <= prod[F_PSU];
      lens_o.rel    <= prod[F_REL];
      lens_o.chg_at <= chg_at;
    end
  end
endmodule

// File: rtl/i2c_sclgen_phase.sv
module i2c_sclgen_phase
  import i2c_sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic [LEN_W-1:0] cnt_nxt_o,
  output logic             last_o
);
  assign cnt_nxt_o = restart_i ? '0 : cnt_o + LEN_W'(1);
  assign last_o    = (cnt_o == len_i - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_nxt_o;
  end
endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
  import i2c_sclgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] tw_cond_i,
  input  logic [31:0] tw_bit_i,
  input  logic [31:0] tw_div_i,
  input  logic [31:0] tw_hold_i,
  input  logic [31:0] cfg_i,
  input  logic        start_i,
  input  logic [1:0]  next_op_i,
  output logic        scl_o,
  output logic [1:0]  sda_mode_o,
  output logic        sda_chg_o,
  output logic        sda_smp_o,
  output logic        busy_o
);
  lens_t            lens;
  phase_e           state_q, state_d;
  logic [LEN_W-1:0] cur_len, cnt, cnt_nxt;
  logic             last, restart;

  i2c_sclgen_calc u_calc (
    .clk(clk), .rst(rst), .tw_cond_i(tw_cond_i), .tw_bit_i(tw_bit_i),
    .tw_div_i(tw_div_i), .tw_hold_i(tw_hold_i), .cfg_i(cfg_i), .lens_o(lens)
  );

  i2c_sclgen_phase u_phase (
    .clk(clk), .rst(rst), .restart_i(restart), .len_i(cur_len),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .last_o(last)
  );

  always_comb begin
    case (state_q)
      ST_S_SU:                      cur_len = lens.ssu;
      ST_S_HD:                      cur_len = lens.shd;
      ST_B_LOW, ST_P_LOW, ST_R_LOW: cur_len = lens.low;
      ST_B_HIGH:                    cur_len = lens.high;
      ST_P_SU:                      cur_len = lens.psu;
      ST_P_FREE:                    cur_len = lens.rel;
      default:                      cur_len = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_S_SU;
      ST_S_SU:   if (last) state_d = ST_S_HD;
      ST_S_HD:   if (last) state_d = ST_B_LOW;
      ST_B_LOW:  if (last) state_d = ST_B_HIGH;
      ST_B_HIGH: if (last) begin
        case (next_op_i)
          2'b01:   state_d = ST_P_LOW;
          2'b10:   state_d = ST_R_LOW;
          default: state_d = ST_B_LOW;
        endcase
      end
      ST_P_LOW:  if (last) state_d = ST_P_SU;
      ST_P_SU:   if (last) state_d = ST_P_FREE;
      ST_P_FREE: if (last) state_d = ST_IDLE;
      ST_R_LOW:  if (last) state_d = ST_S_SU;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign restart = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      scl_o      <= 1'b1;
      sda_mode_o <= SDA_REL;
      sda_chg_o  <= 1'b0;
      sda_smp_o  <= 1'b0;
      busy_o     <= 1'b0;
    end else begin
      state_q    <= state_d;
      scl_o      <= scl_of(state_d);
      sda_mode_o <= mode_of(state_d);
      sda_chg_o  <= (state_d == ST_B_LOW) && (cnt_nxt == lens.chg_at);
      sda_smp_o  <= (state_d == ST_B_HIGH) && (state_q != ST_B_HIGH);
      busy_o     <= (state_d != ST_IDLE);
    end
  end
endmodule

// File: rtl/i2c_sclgen_chk.sv
module i2c_sclgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       scl_o,
  input logic [1:0] sda_mode_o,
  input logic       sda_chg_o,
  input logic       sda_smp_o,
  input logic       busy_o
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (scl_o && sda_mode_o == 2'b10 && !busy_o && !sda_chg_o && !sda_smp_o));

  // R1
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (scl_o && sda_mode_o == 2'b10 && !sda_chg_o && !sda_smp_o));

  // R3
  p_start_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && scl_o && sda_mode_o == 2'b10));

  // R5
  p_chg_in_low_r5: assert property (@(posedge clk) disable iff (rst)
    sda_chg_o |-> (!scl_o && sda_mode_o == 2'b00));

  // R6
  p_smp_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    sda_smp_o |-> (scl_o && !$past(scl_o) && sda_mode_o == 2'b00));

  // R9
  p_cond_edge_high_r9: assert property (@(posedge clk) disable iff (rst)
    ((sda_mode_o == 2'b01 && $past(sda_mode_o) == 2'b10) ||
     (sda_mode_o == 2'b10 && $past(sda_mode_o) == 2'b01)) |-> (scl_o && $past(scl_o)));
endmodule

bind i2c_sclgen i2c_sclgen_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .scl_o(scl_o),
  .sda_mode_o(sda_mode_o), .sda_chg_o(sda_chg_o), .sda_smp_o(sda_smp_o), .busy_o(busy_o)
);

// File: tb/i2c_sclgen_test.sv
module i2c_sclgen_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_DATA = 2'b00, M_LOW = 2'b01, M_REL = 2'b10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tw_cond_i = '0, tw_bit_i = '0, tw_div_i = '0, tw_hold_i = '0, cfg_i = '0;
  logic        start_i = 1'b0;
  logic [1:0]  next_op_i = 2'b00;
  logic        scl_o, sda_chg_o, sda_smp_o, busy_o;
  logic [1:0]  sda_mode_o;

  int checks = 0, errors = 0;
  int chg_idx, smp_idx, chg_cnt, smp_cnt;
  int e_low, e_high, e_ssu, e_shd, e_psu, e_rel, e_chg, e_period;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_sclgen uut (
    .clk(clk), .rst(rst), .tw_cond_i(tw_cond_i), .tw_bit_i(tw_bit_i),
    .tw_div_i(tw_div_i), .tw_hold_i(tw_hold_i), .cfg_i(cfg_i),
    .start_i(start_i), .next_op_i(next_op_i), .scl_o(scl_o),
    .sda_mode_o(sda_mode_o), .sda_chg_o(sda_chg_o), .sda_smp_o(sda_smp_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // count consecutive samples with the given busy/scl/mode, from the current one
  task automatic phase(input string tag, input bit b, input bit s, input logic [1:0] m,
                       input int exp_len);
    int n = 0;
    chg_idx = -1; smp_idx = -1; chg_cnt = 0; smp_cnt = 0;
    while (busy_o == b && scl_o == s && sda_mode_o == m && n < 70000) begin
      if (sda_chg_o) begin if (chg_idx < 0) chg_idx = n; chg_cnt++; end
      if (sda_smp_o) begin if (smp_idx < 0) smp_idx = n; smp_cnt++; end
      n++;
      @(negedge clk);
    end
    check(n == exp_len, tag, n, exp_len);
  endtask

  task automatic set_cfg(input int dv, input int lo, input int hi, input int flt,
                         input int ssu, input int shd, input int psu,
                         input int dsu, input int dhd, input int rel);
    int d = dv + 1;
    int hl, sl;
    tw_cond_i = {8'(ssu), 8'(shd), 8'(psu), 8'h00};
    tw_bit_i  = {8'(dsu), 8'h00, 8'(lo), 8'(hi)};
    tw_div_i  = {8'h00, 8'(dv), 8'h00, 8'(rel)};
    tw_hold_i = {24'h0, 8'(dhd)};
    cfg_i     = {13'h0, 3'(flt), 16'h0};
    e_low  = d * (lo + 1) + 4 + flt;
    e_high = d * (hi + 1) + 4 + flt;
    e_period = d * (lo + hi + 2) + 8 + 2 * flt;
    e_ssu = d * (ssu + 1); e_shd = d * (shd + 1);
    e_psu = d * (psu + 1); e_rel = d * (rel + 1);
    hl = d * (dhd + 1); sl = d * (dsu + 1);
    if (hl + sl <= e_low) e_chg = hl;
    else if (sl < e_low)  e_chg = e_low - sl;
    else                  e_chg = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic start_seq(input string tag);
    phase({tag, " R3 start setup"}, 1'b1, 1'b1, M_REL, e_ssu);
    check(smp_cnt == 0, {tag, " R6 no sample in start setup"}, smp_cnt, 0);
    phase({tag, " R3 start hold"}, 1'b1, 1'b1, M_LOW, e_shd);
    check(smp_cnt == 0, {tag, " R6 no sample in start hold"}, smp_cnt, 0);
  endtask

  task automatic one_bit(input string tag, input logic [1:0] op);
    int lo_n;
    next_op_i = op;
    phase({tag, " R2 bit low"}, 1'b1, 1'b0, M_DATA, e_low);
    lo_n = e_low;
    check(chg_idx == e_chg, {tag, " R5 change strobe position"}, chg_idx, e_chg);
    check(chg_cnt == 1, {tag, " R5 one change strobe"}, chg_cnt, 1);
    phase({tag, " R2 bit high"}, 1'b1, 1'b1, M_DATA, e_high);
    check(smp_idx == 0 && smp_cnt == 1, {tag, " R6 sample strobe on rise"}, smp_idx, 0);
    check(lo_n + e_high == e_period, {tag, " R2 bit period"}, lo_n + e_high, e_period);
  endtask

  task automatic stop_seq(input string tag);
    phase({tag, " R7 stop low"}, 1'b1, 1'b0, M_LOW, e_low);
    check(chg_cnt == 0, {tag, " R5 no change strobe in stop"}, chg_cnt, 0);
    phase({tag, " R7 stop setup"}, 1'b1, 1'b1, M_LOW, e_psu);
    phase({tag, " R7 bus release"}, 1'b1, 1'b1, M_REL, e_rel);
    check(smp_cnt == 0, {tag, " R6 no sample in release"}, smp_cnt, 0);
    check(!busy_o && scl_o && sda_mode_o == M_REL, {tag, " R7 R1 idle after stop"},
          int'(busy_o), 0);
  endtask

  task automatic run_frame(input string tag, input int nbits);
    pulse_start();
    start_seq(tag);
    for (int i = 0; i < nbits; i++)
      one_bit(tag, (i == nbits - 1) ? 2'b01 : 2'b00);
    stop_seq(tag);
  endtask

  task automatic t_reset();
    check(scl_o == 1'b1, "R1 reset scl", int'(scl_o), 1);
    check(sda_mode_o == M_REL, "R1 reset mode", int'(sda_mode_o), int'(M_REL));
    check(!busy_o, "R1 reset busy", int'(busy_o), 0);
    check(!sda_chg_o && !sda_smp_o, "R1 reset strobes", int'(sda_chg_o | sda_smp_o), 0);
  endtask

  task automatic t_basic();
    set_cfg(1, 3, 2, 2, 3, 2, 4, 1, 2, 5);
    run_frame("basic", 3);
  endtask

  task automatic t_restart();
    set_cfg(1, 3, 2, 2, 3, 2, 4, 1, 2, 5);
    start_i = 1'b1;            // held high: R4 requires it to be ignored while busy
    @(negedge clk);
    start_seq("restart");
    one_bit("restart R4", 2'b10);
    next_op_i = 2'b01;
    phase("restart R8 release low", 1'b1, 1'b0, M_REL, e_low);
    phase("restart R8 R4 start setup", 1'b1, 1'b1, M_REL, e_ssu);
    phase("restart R8 R4 start hold", 1'b1, 1'b1, M_LOW, e_shd);
    one_bit("restart R4 after", 2'b01);
    start_i = 1'b0;
    stop_seq("restart");
  endtask

  task automatic t_periods();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame("zero fields", 2);
    set_cfg(3, 10, 7, 7, 1, 2, 3, 0, 1, 1);
    run_frame("large div", 2);
  endtask

  task automatic t_chg_corners();
    set_cfg(1, 3, 2, 2, 3, 2, 4, 1, 5, 5);   // hold-bound would miss setup
    check(e_chg == 10, "R5 setup-bound placement expected", e_chg, 10);
    run_frame("setup bound", 1);
    set_cfg(1, 3, 2, 2, 3, 2, 4, 9, 2, 5);   // setup longer than low phase
    check(e_chg == 0, "R5 first-cycle placement expected", e_chg, 0);
    run_frame("setup exceeds", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_restart();
    t_periods();
    t_chg_corners();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule